// File: doc/BRIEF.md
# Two-Wire Bus Slave Protocol Controller

This block is the protocol front end of a slave device on an open-drain two-wire serial bus. It oversamples the clock and data lines with a fast system clock and finds start, repeated-start and stop conditions. It shifts in the first byte after each start and acknowledges its own seven-bit address by pulling the data line low. The lowest address bit comes from a strap input.

Bytes written to its own address are handed out one at a time, each with a one-cycle strobe. Two special first bytes are handled in the block itself. The high-speed master code sets a mode flag and is never acknowledged. A general-call address followed by the reset code fires a one-cycle soft-reset pulse for the rest of the device. The block only pulls the data line low or releases it, and it never touches the clock line.

Top module: `tw_slave_ctrl`

## Requirements
- R1: A falling data line while the clock is high (START) begins address reception. A rising data line while the clock is high (STOP) returns the controller to idle and releases the data line.
- R2: The address byte is acknowledged when its top seven bits equal 1110100 with the last bit replaced by `addr_sel` (0x74 or 0x75). The lowest bit is the read/write flag, 0 = write. A non-matching address is not acknowledged, and bytes after it are neither acknowledged nor delivered until the next START or STOP.
- R3: `sda_pull` rises only after the clock falls at the end of the eighth bit, so it is low during the eighth high phase. It is high during the ninth clock pulse and released after the clock falls at the end of that pulse. It only changes while the synchronised clock is low.
- R4: Each data byte after a write to the controller's own address is acknowledged. It appears MSB first on `rx_data`, with `rx_valid` high for exactly one cycle.
- R5: A first byte of the form 00001xxx sets `hs_mode` for any xxx and is never acknowledged. The flag stays set across repeated STARTs and clears at the next STOP.
- R6: General-call address 0x00 is acknowledged. A following data byte 0x06 is acknowledged, and when its acknowledge bit ends, `soft_rst` pulses for one cycle, `hs_mode` clears and the controller goes idle.
- R7: A general-call data byte other than 0x06 is not acknowledged, causes no `soft_rst`, and is not delivered on `rx_data`.
- R8: A repeated START in any state, including partway through a data byte, restarts address reception at once. The partial byte is discarded.
- R9: While `rst_n` is low, `sda_pull`, `hs_mode` and `rx_valid` are low and `soft_rst` is high. `soft_rst` drops at the first clock edge after release.
- R10: An own-address byte with the read flag set is acknowledged. Afterwards the data line stays released and nothing is delivered until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the fastest bus clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired with all drivers) |
| addr_sel | input | 1 | Strap giving the lowest address bit |
| sda_pull | output | 1 | Enable for the data-line pull-down |
| hs_mode | output | 1 | High-speed mode flag |
| soft_rst | output | 1 | Device reset pulse (power-on or general call) |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
The address stage is driven with both strap settings and several first bytes. These are a matching write, a matching read, the address that matches only the other strap, the master code with two different low-bit patterns, and the general-call address. Together they separate the acknowledge, ignore, mode-flag and reset paths.

Data bytes go through a scoreboard. Some follow a matching write, some follow a mismatch or a read, and one is cut short by a repeated START. This shows that bytes are delivered only in the right context, and whole. The general-call pair is sent with the reset code and with a wrong code, with the mode flag set beforehand, which shows both the selective acknowledge and the flag clearing.

// File: rtl/tw_pkg.sv
// Shared types for the two-wire slave controller.
// Assumes nothing beyond a byte-oriented bus with a ninth acknowledge bit.
package tw_pkg;

    // Controller phase
    typedef enum logic [2:0] {
        ST_IDLE,       // waiting for START
        ST_RECV,       // shifting in a byte
        ST_WAIT_FALL,  // byte done, acknowledge due at next clock fall
        ST_ACK,        // holding the acknowledge through the ninth bit
        ST_SKIP        // ignoring the bus until START or STOP
    } tw_state_e;

    // What to do when the acknowledge bit ends
    typedef enum logic [1:0] {
        NEXT_DATA,     // receive another data byte
        NEXT_SKIP,     // ignore the rest of the transfer
        NEXT_RESET     // fire the soft reset and go idle
    } tw_next_e;

    // Verdict of the byte classifier
    typedef struct packed {
        logic     ack;      // acknowledge this byte
        logic     hs_set;   // byte was the high-speed master code
        logic     deliver;  // hand byte out on the data port
        logic     gc_open;  // general call is in progress
        tw_next_e next;     // action after the acknowledge bit
    } tw_verdict_t;

endpackage

// File: rtl/tw_line_sync.sv
// Synchroniser and condition detector for the two bus lines.
// Assumes clk runs at least 8x the bus clock; STAGES must be at least 2.
// Both lines reset to the idle-high level so no condition fires at reset.
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] now;
    logic [LINES-1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift one line through its synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign now[g] = chain[STAGES-1];
    end

    // Keep the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= now;
    end

    assign scl_s     = now[0];
    assign scl_rise  = now[0] & ~prev[0];
    assign scl_fall  = ~now[0] & prev[0];
    assign start_det = now[0] & prev[0] & prev[1] & ~now[1];
    assign stop_det  = now[0] & prev[0] & ~prev[1] & now[1];

endmodule

// File: rtl/tw_shift_rx.sv
// Serial-in byte collector: shifts the data bit at each clock rise, MSB first,
// and flags the rise that completes a byte. clr restarts the bit count.
module tw_shift_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sample,
    input  logic         bit_in,
    output logic [W-1:0] byte_next,
    output logic         last
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [W-1:0]  shreg;
    logic [CW-1:0] cnt;

    assign byte_next = {shreg[W-2:0], bit_in};
    assign last      = sample && (cnt == LAST_IDX);

    // Shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clr) begin
            cnt   <= '0;
        end else if (sample) begin
            shreg <= byte_next;
            cnt   <= last ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tw_byte_decode.sv
// Classifies a completed byte: own address, high-speed master code, general
// call, general-call reset code or plain data. Purely combinational.
module tw_byte_decode
    import tw_pkg::*;
#(
    parameter logic [5:0] ADDR_HI   = 6'b111010,
    parameter logic [4:0] HS_PREFIX = 5'b00001,
    parameter logic [7:0] GC_CODE   = 8'h06
) (
    input  logic [7:0]  byte_v,
    input  logic        in_addr,
    input  logic        gc_open,
    input  logic        addr_sel,
    output tw_verdict_t verdict
);
    localparam logic [7:0] GC_ADDR = 8'h00;

    // Decide acknowledge and follow-up for the byte just completed
    always_comb begin
        verdict = '{ack: 1'b0, hs_set: 1'b0, deliver: 1'b0,
                    gc_open: 1'b0, next: NEXT_SKIP};
        if (in_addr) begin
            if (byte_v[7:1] == {ADDR_HI, addr_sel}) begin
                verdict.ack  = 1'b1;
                verdict.next = byte_v[0] ? NEXT_SKIP : NEXT_DATA;
            end else if (byte_v[7:3] == HS_PREFIX) begin
                verdict.hs_set = 1'b1;
            end else if (byte_v == GC_ADDR) begin
                verdict.ack     = 1'b1;
                verdict.gc_open = 1'b1;
                verdict.next    = NEXT_DATA;
            end
        end else if (gc_open) begin
            if (byte_v == GC_CODE) begin
                verdict.ack  = 1'b1;
                verdict.next = NEXT_RESET;
            end
        end else begin
            verdict.ack     = 1'b1;
            verdict.deliver = 1'b1;
            verdict.next    = NEXT_DATA;
        end
    end

endmodule

// File: rtl/tw_slave_ctrl.sv
// Two-wire bus slave protocol controller (top).
// Sequences address/data bytes, drives the acknowledge pull-down only while
// the bus clock is low, tracks high-speed mode and issues the soft reset.
// Assumes clk is at least 8x the bus clock; never drives the clock line.
module tw_slave_ctrl
    import tw_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         BYTE_W      = 8,
    parameter logic [5:0] ADDR_HI     = 6'b111010,
    parameter logic [4:0] HS_PREFIX   = 5'b00001,
    parameter logic [7:0] GC_CODE     = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              addr_sel,
    output logic              sda_pull,
    output logic              hs_mode,
    output logic              soft_rst,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);
    logic        scl_s, scl_rise, scl_fall, start_det, stop_det;
    logic        sda_s;
    logic        shift_clr, byte_last;
    logic [7:0]  byte_next;
    tw_state_e   state;
    tw_next_e    next_q;
    logic        in_addr, gc_open;
    tw_verdict_t verdict;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    // Data level at a clock rise equals the previous level (stable while high)
    assign sda_s     = sda_in_sync;
    logic sda_in_sync;
    // Second tap of the data line aligned with scl_s for bit sampling
    logic [SYNC_STAGES-1:0] sda_chain;
    always_ff @(posedge clk) begin
        if (!rst_n) sda_chain <= '1;
        else        sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
    end
    assign sda_in_sync = sda_chain[SYNC_STAGES-1];

    assign shift_clr = start_det | ((state == ST_ACK) & scl_fall);

    tw_shift_rx #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (shift_clr),
        .sample   (scl_rise),
        .bit_in   (sda_s),
        .byte_next(byte_next),
        .last     (byte_last)
    );

    tw_byte_decode #(
        .ADDR_HI  (ADDR_HI),
        .HS_PREFIX(HS_PREFIX),
        .GC_CODE  (GC_CODE)
    ) u_dec (
        .byte_v  (byte_next),
        .in_addr (in_addr),
        .gc_open (gc_open),
        .addr_sel(addr_sel),
        .verdict (verdict)
    );

    // Protocol sequencer, acknowledge drive, mode flag and reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            next_q   <= NEXT_SKIP;
            in_addr  <= 1'b1;
            gc_open  <= 1'b0;
            sda_pull <= 1'b0;
            hs_mode  <= 1'b0;
            soft_rst <= 1'b1;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            soft_rst <= 1'b0;
            rx_valid <= 1'b0;
            if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                hs_mode  <= 1'b0;
                gc_open  <= 1'b0;
            end else if (start_det) begin
                state    <= ST_RECV;
                in_addr  <= 1'b1;
                gc_open  <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_RECV: begin
                        if (byte_last) begin
                            if (verdict.hs_set)  hs_mode <= 1'b1;
                            if (verdict.deliver) begin
                                rx_data  <= byte_next;
                                rx_valid <= 1'b1;
                            end
                            gc_open <= verdict.gc_open;
                            next_q  <= verdict.next;
                            state   <= verdict.ack ? ST_WAIT_FALL : ST_SKIP;
                        end
                    end
                    ST_WAIT_FALL: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b1;
                            state    <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            in_addr  <= 1'b0;
                            unique case (next_q)
                                NEXT_DATA:  state <= ST_RECV;
                                NEXT_RESET: begin
                                    state    <= ST_IDLE;
                                    hs_mode  <= 1'b0;
                                    gc_open  <= 1'b0;
                                    soft_rst <= 1'b1;
                                end
                                default:    state <= ST_SKIP;
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tw_slave_ctrl_chk.sv
// Property checker for tw_slave_ctrl, attached by bind below.
// Observes the synchronised clock level and stop condition inside the top.
module tw_slave_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic stop_det,
    input logic sda_pull,
    input logic hs_mode,
    input logic soft_rst,
    input logic rx_valid
);
    // R3
    pull_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull) || $fell(sda_pull)) |-> !scl_s);

    // R5
    hs_cleared_by_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs_mode);

    // R1
    stop_releases_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    // R6
    soft_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    // R4
    rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

bind tw_slave_ctrl tw_slave_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .stop_det(stop_det),
    .sda_pull(sda_pull),
    .hs_mode (hs_mode),
    .soft_rst(soft_rst),
    .rx_valid(rx_valid)
);

// File: tb/tw_slave_ctrl_test.sv
// Scoreboard bench: the bus driver pushes expected data bytes into a queue,
// a monitor pops and compares them whenever the design strobes a byte.
module tw_slave_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int QTR  = 8;   // system clocks per quarter bit
    localparam int HIGH = 16;  // system clocks of clock-high time

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_line;
    logic       sda_pull, hs_mode, soft_rst, rx_valid;
    logic [7:0] rx_data;

    int         checks = 0;
    int         failures = 0;
    int         soft_cnt = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];

    assign sda_line = sda_drv & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_slave_ctrl uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_drv),
        .sda_in  (sda_line),
        .addr_sel(addr_sel),
        .sda_pull(sda_pull),
        .hs_mode (hs_mode),
        .soft_rst(soft_rst),
        .rx_data (rx_data),
        .rx_valid(rx_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: count soft resets and compare delivered bytes with the queue
    always @(negedge clk) begin
        logic [7:0] e;
        if (rst_n && !done) begin
            if (soft_rst) soft_cnt++;
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected byte", rx_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(rx_data == e, "R4 byte value", rx_data, e);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // START from idle, or repeated START with the clock low
    task automatic bus_start();
        sda_drv = 1'b1; wait_clk(QTR);
        scl_drv = 1'b1; wait_clk(QTR);
        sda_drv = 1'b0; wait_clk(QTR);
        scl_drv = 1'b0; wait_clk(QTR);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_clk(QTR);
        scl_drv = 1'b1; wait_clk(QTR);
        sda_drv = 1'b1; wait_clk(QTR);
    endtask

    task automatic clock_bit(input logic b);
        sda_drv = b;    wait_clk(QTR);
        scl_drv = 1'b1; wait_clk(HIGH);
        scl_drv = 1'b0; wait_clk(QTR);
    endtask

    // Eight data bits plus the acknowledge clock, checking the pull-down
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wait_clk(QTR);
            scl_drv = 1'b1;
            if (i == 0) begin
                wait_clk(HIGH/2);
                check(sda_pull == 1'b0, "R3 no pull in eighth bit", sda_pull, 0);
                wait_clk(HIGH/2);
            end else begin
                wait_clk(HIGH);
            end
            scl_drv = 1'b0; wait_clk(QTR);
        end
        sda_drv = 1'b1; wait_clk(QTR);
        scl_drv = 1'b1; wait_clk(HIGH/2);
        check(sda_pull == exp_ack, req, sda_pull, exp_ack);
        wait_clk(HIGH/2);
        scl_drv = 1'b0; wait_clk(QTR);
        if (exp_ack) check(sda_pull == 1'b0, "R3 release after ninth bit", sda_pull, 0);
    endtask

    initial begin
        // R9 reset state
        wait_clk(5);
        check(soft_rst == 1'b1, "R9 soft_rst in reset", soft_rst, 1);
        check(sda_pull == 1'b0, "R9 sda_pull in reset", sda_pull, 0);
        check(hs_mode == 1'b0, "R9 hs_mode in reset", hs_mode, 0);
        check(rx_valid == 1'b0, "R9 rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        wait_clk(3);
        check(soft_rst == 1'b0, "R9 soft_rst after release", soft_rst, 0);

        // R2/R4 own write address with strap low, two data bytes
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'hE8, 1'b1, "R2 address 0x74 acked");
        exp_q.push_back(8'hA5);
        send_byte(8'hA5, 1'b1, "R4 data acked");
        exp_q.push_back(8'h3C);
        send_byte(8'h3C, 1'b1, "R4 data acked");
        bus_stop();
        check(exp_q.size() == 0, "R4 bytes delivered", exp_q.size(), 0);

        // R2 strap high: 0x74 no longer matches, following byte ignored
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'hE8, 1'b0, "R2 mismatch not acked");
        send_byte(8'h11, 1'b0, "R2 byte after mismatch ignored");
        bus_stop();
        check(sda_pull == 1'b0, "R1 released after STOP", sda_pull, 0);

        // R1 after STOP a new START is decoded; R2 address 0x75
        bus_start();
        send_byte(8'hEA, 1'b1, "R1 R2 address 0x75 acked after STOP");
        exp_q.push_back(8'h5A);
        send_byte(8'h5A, 1'b1, "R4 data acked");
        bus_stop();

        // R10 read request acked, then nothing driven or delivered
        bus_start();
        send_byte(8'hEB, 1'b1, "R10 read address acked");
        send_byte(8'hFF, 1'b0, "R10 no pull after read address");
        bus_stop();

        // R5 master code, held across repeated START, cleared by STOP
        bus_start();
        send_byte(8'h0D, 1'b0, "R5 master code not acked");
        check(hs_mode == 1'b1, "R5 hs set", hs_mode, 1);
        bus_start();
        check(hs_mode == 1'b1, "R5 hs held across repeated START", hs_mode, 1);
        send_byte(8'hEA, 1'b1, "R5 address acked in hs mode");
        exp_q.push_back(8'h77);
        send_byte(8'h77, 1'b1, "R4 data acked in hs mode");
        bus_stop();
        check(hs_mode == 1'b0, "R5 hs cleared by STOP", hs_mode, 0);

        // R6 general-call reset, with hs set beforehand
        bus_start();
        send_byte(8'h08, 1'b0, "R5 master code low bits zero not acked");
        check(hs_mode == 1'b1, "R5 hs set by 0x08", hs_mode, 1);
        soft_cnt = 0;
        bus_start();
        send_byte(8'h00, 1'b1, "R6 general call acked");
        send_byte(8'h06, 1'b1, "R6 reset code acked");
        check(soft_cnt == 1, "R6 one soft reset pulse", soft_cnt, 1);
        check(hs_mode == 1'b0, "R6 hs cleared by soft reset", hs_mode, 0);
        bus_stop();

        // R7 general call with a wrong code
        soft_cnt = 0;
        bus_start();
        send_byte(8'h00, 1'b1, "R7 general call acked");
        send_byte(8'h04, 1'b0, "R7 wrong code not acked");
        bus_stop();
        check(soft_cnt == 0, "R7 no soft reset", soft_cnt, 0);

        // R8 repeated START cuts a data byte short
        bus_start();
        send_byte(8'hEA, 1'b1, "R8 address acked");
        clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1); clock_bit(1'b1);
        bus_start();
        send_byte(8'hEA, 1'b1, "R8 address acked after repeated START");
        exp_q.push_back(8'hC3);
        send_byte(8'hC3, 1'b1, "R8 data acked after restart");
        bus_stop();
        wait_clk(10);
        check(exp_q.size() == 0, "R8 only whole bytes delivered", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule